// File: doc/BRIEF.md
# Tagged Fully Associative Translation Cache

This block holds a small set of recently used page translations and answers one address lookup per cycle. A lookup presents a virtual address, an address space identifier and an access kind. Every stored entry is compared against the request at the same time. An entry matches only when its page number and its space identifier both equal the request. When an entry matches, the block returns the physical address one cycle later. That address is the stored frame number joined to the untouched 12-bit page offset. The block also reports whether the stored permission bits allow the access.

When no entry matches, the block raises a refill request. A walker or software agent outside the block then supplies the missing translation through the fill port. A fill goes into a slot chosen in three steps. If an entry already holds the same page and identifier, the fill overwrites it. Otherwise the lowest-numbered empty slot takes it. Otherwise a slot picked by a free-running pseudo-random sequence is replaced. Two maintenance inputs remove translations: one invalidates every entry, and the other invalidates only the entries of one address space.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, all result outputs are low, and the first lookup misses.
- R2: A lookup presented with `lkValid` in one cycle produces `rsValid` in the next cycle, with exactly one of `rsHit` and `rsMiss` set.
- R3: A hit requires both the virtual page number and the address space identifier to equal a valid entry's. The same page under a different identifier misses, and two identifiers may map the same page to different frames.
- R4: On a miss, `rsMiss` (the refill request) is high, `rsFault` is low and `rsPaddr` is zero.
- R5: `fillPerm` bit 0 allows read, bit 1 allows write and bit 2 allows execute. `lkAccess` 0 is read, 1 is write, 2 is execute, and 3 is reserved and never allowed. A hit whose access is not allowed sets `rsFault`, and the physical address is still returned.
- R6: On a hit, `rsPaddr` equals the entry's frame number in the upper bits, with the lowest 12 address bits passed through unchanged.
- R7: While any slot is empty, a fill never displaces a valid entry.
- R8: When all slots are full, a fill of a new translation replaces exactly one existing entry, and the new translation then hits.
- R9: A fill whose page and identifier match an existing entry overwrites that entry in place. The new frame is returned, no other entry is lost, and no duplicate translation ever exists.
- R10: `flushAll` invalidates every entry.
- R11: `flushAsidValid` invalidates only the entries tagged with `flushAsid`. Entries of other identifiers still hit.
- R12: A fill in the same cycle as a flush is applied after the flush, so the filled translation survives.
- R13: A lookup in the same cycle as a fill sees the contents from before the fill. Lookups issued on consecutive cycles each get their own result on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkValid | input | 1 | Lookup request strobe |
| lkVaddr | input | VPN_W+OFF_W | Virtual address to translate |
| lkAsid | input | ASID_W | Address space identifier of the lookup |
| lkAccess | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| fillValid | input | 1 | Install a translation |
| fillAsid | input | ASID_W | Identifier of the installed translation |
| fillVpn | input | VPN_W | Virtual page number installed |
| fillPfn | input | PFN_W | Physical frame number installed |
| fillPerm | input | 3 | Permissions {execute, write, read} |
| flushAll | input | 1 | Invalidate all entries |
| flushAsidValid | input | 1 | Invalidate entries of one identifier |
| flushAsid | input | ASID_W | Identifier to invalidate |
| rsValid | output | 1 | Result present |
| rsHit | output | 1 | Translation found |
| rsMiss | output | 1 | Translation absent; refill request |
| rsFault | output | 1 | Hit with the access not permitted |
| rsPaddr | output | PFN_W+OFF_W | Physical address on hit, zero on miss |

## Verification
The lookup path is tried with page numbers that are present under the right identifier, present only under another identifier, and absent. This separates the effect of the identifier from the effect of the page comparison. Each access kind is run against a read-only entry and a write-execute entry, which tells a wrong permission bit from a wrong access decode. Fills are tried in several situations: into a partly empty table, a full table, and a table already holding the same page. Eviction is measured by counting how many earlier pages still hit. Flushes are tried on their own, by identifier, and in the same cycle as a fill, and a fill is also overlapped with a lookup, to pin down the order in which same-cycle operations take effect.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // Width of the slot index carried in the strobe struct; supports up to 64 slots.
  localparam int unsigned IDX_FIELD_W = 6;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } access_e;

  typedef enum logic [1:0] {
    VIC_DUP  = 2'd0,
    VIC_FREE = 2'd1,
    VIC_RAND = 2'd2
  } victim_src_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                   fillWr;
    logic [IDX_FIELD_W-1:0] fillIdx;
    logic                   clrAll;
    logic                   clrAsid;
  } ctrl_strobe_t;

  // perm = {exec, write, read}
  function automatic logic accessAllowed(input logic [2:0] perm, input access_e acc);
    logic ok;
    case (acc)
      ACC_READ:  ok = perm[0];
      ACC_WRITE: ok = perm[1];
      ACC_EXEC:  ok = perm[2];
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillValid,
  input  logic               flushAll,
  input  logic               flushAsidValid,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] fillHitVec,
  output ctrl_strobe_t       strobe
);

  localparam logic [15:0] LFSR_SEED = 16'hACE1;
  localparam logic [15:0] LFSR_TAPS = 16'hB400;

  logic [15:0]            lfsr;
  logic [IDX_FIELD_W-1:0] dupIdx;
  logic [IDX_FIELD_W-1:0] freeIdx;
  logic [IDX_FIELD_W-1:0] rndIdx;
  logic                   anyDup;
  logic                   anyFree;
  victim_src_e            victimSrc;

  // Free-running Galois LFSR, advances every cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr <= LFSR_SEED;
    end else begin
      lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? LFSR_TAPS : 16'h0000);
    end
  end

  // Lowest-index matching slot and lowest-index empty slot.
  always_comb begin
    dupIdx  = '0;
    freeIdx = '0;
    for (int i = int'(ENTRIES) - 1; i >= 0; i--) begin
      if (fillHitVec[i]) dupIdx = IDX_FIELD_W'(i);
      if (!validVec[i])  freeIdx = IDX_FIELD_W'(i);
    end
  end

  assign anyDup  = |fillHitVec;
  assign anyFree = ~&validVec;
  assign rndIdx  = IDX_FIELD_W'(lfsr % 16'(ENTRIES));

  always_comb begin
    if (anyDup)       victimSrc = VIC_DUP;
    else if (anyFree) victimSrc = VIC_FREE;
    else              victimSrc = VIC_RAND;
  end

  always_comb begin
    strobe.fillWr  = fillValid;
    strobe.clrAll  = flushAll;
    strobe.clrAsid = flushAsidValid;
    case (victimSrc)
      VIC_DUP:  strobe.fillIdx = dupIdx;
      VIC_FREE: strobe.fillIdx = freeIdx;
      default:  strobe.fillIdx = rndIdx;
    endcase
  end

endmodule

// File: rtl/xlat_dp.sv
module xlat_dp
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PFN_W   = 20,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned OFF_W   = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrl_strobe_t           strobe,
  input  logic                   lkValid,
  input  logic [VPN_W-1:0]       lkVpn,
  input  logic [OFF_W-1:0]       lkOff,
  input  logic [ASID_W-1:0]      lkAsid,
  input  logic [1:0]             lkAccess,
  input  logic [ASID_W-1:0]      fillAsid,
  input  logic [VPN_W-1:0]       fillVpn,
  input  logic [PFN_W-1:0]       fillPfn,
  input  logic [2:0]             fillPerm,
  input  logic [ASID_W-1:0]      flushAsid,
  output logic [ENTRIES-1:0]     validVec,
  output logic [ENTRIES-1:0]     fillHitVec,
  output logic                   rsValid,
  output logic                   rsHit,
  output logic                   rsMiss,
  output logic                   rsFault,
  output logic [PFN_W+OFF_W-1:0] rsPaddr
);

  localparam int unsigned PA_W = PFN_W + OFF_W;

  logic [ENTRIES-1:0] lkHitVec;
  logic [PFN_W-1:0]   pfnMasked  [ENTRIES];
  logic [2:0]         permMasked [ENTRIES];
  logic [PFN_W-1:0]   selPfn;
  logic [2:0]         selPerm;
  logic               anyHit;
  logic               permOk;

  for (genvar g = 0; g < int'(ENTRIES); g++) begin : g_ent
    logic              vldQ;
    logic [ASID_W-1:0] asidQ;
    logic [VPN_W-1:0]  vpnQ;
    logic [PFN_W-1:0]  pfnQ;
    logic [2:0]        permQ;
    logic              fillSel;
    logic              flushHit;

    assign fillSel  = strobe.fillWr && (strobe.fillIdx == IDX_FIELD_W'(g));
    assign flushHit = strobe.clrAll || (strobe.clrAsid && (asidQ == flushAsid));

    // Fill is applied after any flush in the same cycle.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vldQ <= 1'b0;
      end else if (fillSel) begin
        vldQ <= 1'b1;
      end else if (flushHit) begin
        vldQ <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (fillSel) begin
        asidQ <= fillAsid;
        vpnQ  <= fillVpn;
        pfnQ  <= fillPfn;
        permQ <= fillPerm;
      end
    end

    assign validVec[g]   = vldQ;
    assign lkHitVec[g]   = vldQ && (vpnQ == lkVpn) && (asidQ == lkAsid);
    assign fillHitVec[g] = vldQ && (vpnQ == fillVpn) && (asidQ == fillAsid);
    assign pfnMasked[g]  = lkHitVec[g] ? pfnQ  : '0;
    assign permMasked[g] = lkHitVec[g] ? permQ : '0;
  end

  // At most one entry matches, so an OR tree selects the hit.
  always_comb begin
    selPfn  = '0;
    selPerm = '0;
    for (int i = 0; i < int'(ENTRIES); i++) begin
      selPfn  = selPfn  | pfnMasked[i];
      selPerm = selPerm | permMasked[i];
    end
  end

  assign anyHit = |lkHitVec;
  assign permOk = accessAllowed(selPerm, access_e'(lkAccess));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rsValid <= 1'b0;
      rsHit   <= 1'b0;
      rsMiss  <= 1'b0;
      rsFault <= 1'b0;
      rsPaddr <= '0;
    end else begin
      rsValid <= lkValid;
      rsHit   <= lkValid && anyHit;
      rsMiss  <= lkValid && !anyHit;
      rsFault <= lkValid && anyHit && !permOk;
      rsPaddr <= (lkValid && anyHit) ? {selPfn, lkOff} : PA_W'(0);
    end
  end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PFN_W   = 20,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned OFF_W   = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lkValid,
  input  logic [VPN_W+OFF_W-1:0] lkVaddr,
  input  logic [ASID_W-1:0]      lkAsid,
  input  logic [1:0]             lkAccess,
  input  logic                   fillValid,
  input  logic [ASID_W-1:0]      fillAsid,
  input  logic [VPN_W-1:0]       fillVpn,
  input  logic [PFN_W-1:0]       fillPfn,
  input  logic [2:0]             fillPerm,
  input  logic                   flushAll,
  input  logic                   flushAsidValid,
  input  logic [ASID_W-1:0]      flushAsid,
  output logic                   rsValid,
  output logic                   rsHit,
  output logic                   rsMiss,
  output logic                   rsFault,
  output logic [PFN_W+OFF_W-1:0] rsPaddr
);

  localparam int unsigned VA_W = VPN_W + OFF_W;

  ctrl_strobe_t       strobe;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] fillHitVec;

  xlat_ctrl #(
    .ENTRIES(ENTRIES)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .fillValid     (fillValid),
    .flushAll      (flushAll),
    .flushAsidValid(flushAsidValid),
    .validVec      (validVec),
    .fillHitVec    (fillHitVec),
    .strobe        (strobe)
  );

  xlat_dp #(
    .ENTRIES(ENTRIES),
    .VPN_W  (VPN_W),
    .PFN_W  (PFN_W),
    .ASID_W (ASID_W),
    .OFF_W  (OFF_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .lkValid   (lkValid),
    .lkVpn     (lkVaddr[VA_W-1:OFF_W]),
    .lkOff     (lkVaddr[OFF_W-1:0]),
    .lkAsid    (lkAsid),
    .lkAccess  (lkAccess),
    .fillAsid  (fillAsid),
    .fillVpn   (fillVpn),
    .fillPfn   (fillPfn),
    .fillPerm  (fillPerm),
    .flushAsid (flushAsid),
    .validVec  (validVec),
    .fillHitVec(fillHitVec),
    .rsValid   (rsValid),
    .rsHit     (rsHit),
    .rsMiss    (rsMiss),
    .rsFault   (rsFault),
    .rsPaddr   (rsPaddr)
  );

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned PA_W    = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               lkValid,
  input logic               fillValid,
  input logic               flushAll,
  input logic [ENTRIES-1:0] validVec,
  input logic [ENTRIES-1:0] fillHitVec,
  input logic               rsValid,
  input logic               rsHit,
  input logic               rsMiss,
  input logic               rsFault,
  input logic [PA_W-1:0]    rsPaddr
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rsValid |-> (!rsHit && !rsMiss && !rsFault));

  // R2
  lookup_reply_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> (rsValid && (rsHit ^ rsMiss)));

  // R4
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rsMiss |-> (rsPaddr == '0 && !rsFault));

  // R5
  fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    rsFault |-> rsHit);

  // R9
  no_dup_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fillHitVec));

  // R10
  flush_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flushAll && !fillValid) |=> (validVec == '0));

  // R12
  flush_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flushAll && fillValid) |=> ($countones(validVec) == 1));

endmodule

bind xlat_cache xlat_cache_chk #(
  .ENTRIES(ENTRIES),
  .PA_W   (PFN_W + OFF_W)
) u_chk (.*);

// File: tb/test_xlat_cache.sv
module test_xlat_cache;

  localparam int ENTRIES = 8;
  localparam int VPN_W   = 20;
  localparam int PFN_W   = 20;
  localparam int ASID_W  = 8;
  localparam int OFF_W   = 12;
  localparam int VA_W    = VPN_W + OFF_W;
  localparam int PA_W    = PFN_W + OFF_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              lkValid = 1'b0;
  logic [VA_W-1:0]   lkVaddr = '0;
  logic [ASID_W-1:0] lkAsid = '0;
  logic [1:0]        lkAccess = '0;
  logic              fillValid = 1'b0;
  logic [ASID_W-1:0] fillAsid = '0;
  logic [VPN_W-1:0]  fillVpn = '0;
  logic [PFN_W-1:0]  fillPfn = '0;
  logic [2:0]        fillPerm = '0;
  logic              flushAll = 1'b0;
  logic              flushAsidValid = 1'b0;
  logic [ASID_W-1:0] flushAsid = '0;
  logic              rsValid, rsHit, rsMiss, rsFault;
  logic [PA_W-1:0]   rsPaddr;

  always #4 clk = ~clk;

  xlat_cache #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .OFF_W(OFF_W)
  ) i_xlat_cache (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVaddr(lkVaddr), .lkAsid(lkAsid),
    .lkAccess(lkAccess), .fillValid(fillValid), .fillAsid(fillAsid), .fillVpn(fillVpn),
    .fillPfn(fillPfn), .fillPerm(fillPerm), .flushAll(flushAll),
    .flushAsidValid(flushAsidValid), .flushAsid(flushAsid), .rsValid(rsValid),
    .rsHit(rsHit), .rsMiss(rsMiss), .rsFault(rsFault), .rsPaddr(rsPaddr)
  );

  // kind 0: exact compare; kind 1: only count hits (victim unknown)
  typedef struct {
    int              kind;
    logic            hit;
    logic            fault;
    logic [PA_W-1:0] pa;
    string           req;
  } exp_t;

  exp_t expQ[$];
  exp_t cur;
  int   nChecks = 0;
  int   nFails  = 0;
  int   cntHits = 0;
  bit   finished = 1'b0;

  // Monitor: results sampled at the falling edge.
  always @(negedge clk) begin
    if (rstN && rsValid) begin
      if (expQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL R2: unexpected result act=1 exp=0");
      end else begin
        cur = expQ.pop_front();
        if (cur.kind == 1) begin
          if (rsHit) begin
            cntHits++;
            nChecks++;
            if (rsPaddr !== cur.pa) begin
              nFails++;
              $display("FAIL %s: paddr act=%h exp=%h", cur.req, rsPaddr, cur.pa);
            end
          end
        end else begin
          nChecks++;
          if (rsHit !== cur.hit || rsMiss !== !cur.hit || rsFault !== cur.fault ||
              rsPaddr !== cur.pa) begin
            nFails++;
            $display("FAIL %s: hit/miss/fault/pa act=%b/%b/%b/%h exp=%b/%b/%b/%h",
                     cur.req, rsHit, rsMiss, rsFault, rsPaddr,
                     cur.hit, !cur.hit, cur.fault, cur.pa);
          end
        end
      end
    end
  end

  task automatic clearStrobes();
    lkValid = 1'b0; fillValid = 1'b0; flushAll = 1'b0; flushAsidValid = 1'b0;
  endtask

  task automatic setLook(input logic [ASID_W-1:0] a, input logic [VPN_W-1:0] v,
                         input logic [OFF_W-1:0] off, input logic [1:0] acc,
                         input bit hit, input bit flt, input logic [PFN_W-1:0] pfn,
                         input string req, input int kind);
    exp_t e;
    lkValid = 1'b1; lkAsid = a; lkVaddr = {v, off}; lkAccess = acc;
    e.kind = kind; e.hit = hit; e.fault = flt; e.req = req;
    e.pa = hit ? {pfn, off} : '0;
    expQ.push_back(e);
  endtask

  task automatic setFill(input logic [ASID_W-1:0] a, input logic [VPN_W-1:0] v,
                         input logic [PFN_W-1:0] p, input logic [2:0] perm);
    fillValid = 1'b1; fillAsid = a; fillVpn = v; fillPfn = p; fillPerm = perm;
  endtask

  task automatic look(input logic [ASID_W-1:0] a, input logic [VPN_W-1:0] v,
                      input logic [OFF_W-1:0] off, input logic [1:0] acc,
                      input bit hit, input bit flt, input logic [PFN_W-1:0] pfn,
                      input string req, input int kind = 0);
    @(negedge clk);
    clearStrobes();
    setLook(a, v, off, acc, hit, flt, pfn, req, kind);
  endtask

  task automatic fill(input logic [ASID_W-1:0] a, input logic [VPN_W-1:0] v,
                      input logic [PFN_W-1:0] p, input logic [2:0] perm);
    @(negedge clk);
    clearStrobes();
    setFill(a, v, p, perm);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      clearStrobes();
    end
  endtask

  task automatic checkEq(input int act, input int exp, input string req, input string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    checkEq(int'({rsValid, rsHit, rsMiss, rsFault}), 0, "R1", "outputs after reset");
    look(8'd1, 20'h100, 12'h000, 2'd0, 0, 0, '0, "R1");

    // R7, R6, R13: fill all slots, back-to-back lookups all hit
    for (int i = 0; i < ENTRIES; i++) fill(8'd1, 20'h100 + 20'(i), 20'h500 + 20'(i), 3'b111);
    for (int i = 0; i < ENTRIES; i++)
      look(8'd1, 20'h100 + 20'(i), 12'(i * 'h111), 2'd0, 1, 0, 20'h500 + 20'(i), "R7/R6/R13");
    // R3: other identifier misses; R4: absent page misses
    look(8'd2, 20'h100, 12'h004, 2'd0, 0, 0, '0, "R3");
    look(8'd1, 20'h3FF, 12'h008, 2'd0, 0, 0, '0, "R4");

    // R8: full table, new translation evicts exactly one
    fill(8'd1, 20'h200, 20'h600, 3'b111);
    look(8'd1, 20'h200, 12'hABC, 2'd0, 1, 0, 20'h600, "R8");
    idle(2);
    cntHits = 0;
    for (int i = 0; i < ENTRIES; i++)
      look(8'd1, 20'h100 + 20'(i), 12'h010, 2'd0, 1, 0, 20'h500 + 20'(i), "R8", 1);
    idle(3);
    checkEq(cntHits, ENTRIES - 1, "R8", "old entries still hitting");

    // R9: duplicate fill overwrites in place, nothing else lost
    fill(8'd1, 20'h200, 20'h777, 3'b111);
    look(8'd1, 20'h200, 12'h123, 2'd0, 1, 0, 20'h777, "R9");
    idle(2);
    cntHits = 0;
    for (int i = 0; i < ENTRIES; i++)
      look(8'd1, 20'h100 + 20'(i), 12'h020, 2'd0, 1, 0, 20'h500 + 20'(i), "R9", 1);
    idle(3);
    checkEq(cntHits, ENTRIES - 1, "R9", "old entries after duplicate fill");

    // R10: flush everything
    @(negedge clk); clearStrobes(); flushAll = 1'b1;
    look(8'd1, 20'h100, 12'h000, 2'd0, 0, 0, '0, "R10");
    look(8'd1, 20'h107, 12'h000, 2'd0, 0, 0, '0, "R10");
    look(8'd1, 20'h200, 12'h000, 2'd0, 0, 0, '0, "R10");

    // R3: same page under two identifiers
    fill(8'd2, 20'h010, 20'hA10, 3'b111);
    fill(8'd2, 20'h011, 20'hA11, 3'b111);
    fill(8'd3, 20'h010, 20'hB10, 3'b111);
    look(8'd2, 20'h010, 12'h0F0, 2'd0, 1, 0, 20'hA10, "R3");
    look(8'd3, 20'h010, 12'h0F0, 2'd0, 1, 0, 20'hB10, "R3");
    look(8'd4, 20'h010, 12'h0F0, 2'd0, 0, 0, '0, "R3");

    // R11: flush by identifier
    @(negedge clk); clearStrobes(); flushAsidValid = 1'b1; flushAsid = 8'd2;
    look(8'd2, 20'h010, 12'h001, 2'd0, 0, 0, '0, "R11");
    look(8'd2, 20'h011, 12'h001, 2'd0, 0, 0, '0, "R11");
    look(8'd3, 20'h010, 12'h001, 2'd0, 1, 0, 20'hB10, "R11");

    // R13: lookup in the fill cycle sees old contents
    @(negedge clk); clearStrobes();
    setFill(8'd5, 20'h020, 20'hC20, 3'b111);
    setLook(8'd5, 20'h020, 12'h055, 2'd0, 0, 0, '0, "R13", 0);
    look(8'd5, 20'h020, 12'h055, 2'd0, 1, 0, 20'hC20, "R13");

    // R12: fill and full flush together, fill survives
    @(negedge clk); clearStrobes();
    flushAll = 1'b1;
    setFill(8'd6, 20'h030, 20'hD30, 3'b111);
    look(8'd6, 20'h030, 12'h777, 2'd0, 1, 0, 20'hD30, "R12");
    look(8'd3, 20'h010, 12'h777, 2'd0, 0, 0, '0, "R12");
    look(8'd5, 20'h020, 12'h777, 2'd0, 0, 0, '0, "R12");

    // R5: permissions
    fill(8'd7, 20'h040, 20'hE40, 3'b001);
    fill(8'd7, 20'h041, 20'hE41, 3'b110);
    look(8'd7, 20'h040, 12'h100, 2'd0, 1, 0, 20'hE40, "R5");
    look(8'd7, 20'h040, 12'h100, 2'd1, 1, 1, 20'hE40, "R5");
    look(8'd7, 20'h040, 12'h100, 2'd2, 1, 1, 20'hE40, "R5");
    look(8'd7, 20'h040, 12'h100, 2'd3, 1, 1, 20'hE40, "R5");
    look(8'd7, 20'h041, 12'h200, 2'd0, 1, 1, 20'hE41, "R5");
    look(8'd7, 20'h041, 12'h200, 2'd1, 1, 0, 20'hE41, "R5");
    look(8'd7, 20'h041, 12'h200, 2'd2, 1, 0, 20'hE41, "R5");
    look(8'd7, 20'h041, 12'h200, 2'd3, 1, 1, 20'hE41, "R5");

    idle(4);
    checkEq(expQ.size(), 0, "R2", "results outstanding");
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL R2: watchdog expired act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule